// File: doc/BRIEF.md
# I2C Memory Slave Front End

This block is the serial front end of a small register and nonvolatile memory device. It follows a two-wire bus as a slave and answers one of two 7-bit addresses, chosen by a select pin. A write transfer supplies one memory address byte and then any number of data bytes. A read transfer returns bytes starting from an internal 8-bit address counter, which keeps its value from one transfer to the next.

On the inside it offers a plain byte bus. The bus carries the counter as the memory address, the received data byte and a one-cycle write strobe. It takes a read data input that the memory presents combinationally for the current address. A one-cycle pulse marks a stop that ends a transfer this slave took part in, so a storage engine can begin committing data. While that engine reports busy, the slave leaves its address unacknowledged, which lets a master poll for completion.

Both bus lines are sampled into the system clock domain through a short synchroniser. The slave never holds the clock low. Its only drive is a single enable that pulls the data line low.

Top module: `i2c_mem_slave`

## Requirements
- R1: The slave acknowledges, by asserting `sda_drive_low` through the ninth clock, only the address byte whose upper seven bits equal 1010000b when `addr_sel` is 0 or 1010001b when `addr_sel` is 1. Bit 0 of that byte is the direction: 0 means write, 1 means read. After any other address it drives nothing until the next start.
- R2: If `busy` is high when the address byte completes, the address is not acknowledged. The rest of the transfer produces no acknowledge, no write strobe and no stop pulse.
- R3: In a write transfer, the first byte after the address loads the address counter and is acknowledged. Each later byte is acknowledged and produces exactly one `mem_we` cycle, with `mem_addr` equal to the counter and `mem_wdata` equal to the byte.
- R4: The counter advances by one after each data byte written or read, and rolls from FFh to 00h with no page wrap.
- R5: A read transfer with no preceding address byte starts at the counter value left by the previous transfer.
- R6: A write address followed by a repeated start and a read address makes the read begin at the memory address just sent.
- R7: Read bytes are sent MSB first. A master acknowledge fetches the next byte. A master NACK makes the slave release the data line and ignore further clocks until a start.
- R8: `stop_pulse` is high for exactly one cycle after a stop that ends a transfer whose address was acknowledged. Any other stop produces no pulse.
- R9: During reset `sda_drive_low`, `mem_we` and `stop_pulse` are low and the counter is 00h.
- R10: A stop or start in the middle of a byte abandons that byte: no write strobe, and the counter is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_sel | input | 1 | Selects the low bit of the slave address |
| busy | input | 1 | Storage engine busy; suppresses the address acknowledge |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_drive_low | output | 1 | Pull the data line low when high |
| mem_addr | output | 8 | Address counter presented to the memory |
| mem_wdata | output | 8 | Received data byte |
| mem_we | output | 1 | One-cycle write strobe |
| mem_rdata | input | 8 | Memory data at `mem_addr` |
| stop_pulse | output | 1 | One-cycle pulse at the end of an addressed transfer |

## Verification
The hardest cases to reach are the ones that involve the counter's history. Examples are a read with no address byte, which depends on every earlier transfer, and a counter crossing FFh mid-burst. The bench writes a burst from FCh so that the writes cross the top of memory. It then issues bare reads, and a dummy write to FEh with a repeated start, and checks every byte against a model it keeps from its own traffic. It also aborts a byte with a stop after three bits, so the counter's value at that point is checked by the next read.

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave #(
  parameter logic [6:0] BASE_ADDR = 7'b1010000,
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr_sel,
  input  logic       busy,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_drive_low,
  output logic [7:0] mem_addr,
  output logic [7:0] mem_wdata,
  output logic       mem_we,
  input  logic [7:0] mem_rdata,
  output logic       stop_pulse
);

  typedef enum logic [3:0] {
    S_IDLE, S_DEV, S_DEV_ACK, S_REG, S_REG_ACK, S_WR, S_WR_ACK, S_RD, S_RD_ACK
  } state_t;

  state_t state;
  logic [SYNC-1:0] scl_sy, sda_sy;
  logic scl_d, sda_d;
  logic [7:0] sr, tx, ctr;
  logic [2:0] bitcnt;
  logic full, ack_q, rw, mack, sel;

  wire scl_s = scl_sy[SYNC-1];
  wire sda_s = sda_sy[SYNC-1];
  wire scl_rise = scl_s & ~scl_d;
  wire scl_fall = ~scl_s & scl_d;
  wire start_c = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_c  = scl_s & scl_d & ~sda_d & sda_s;
  wire [6:0] dev_addr = BASE_ADDR | {6'b0, addr_sel};

  assign sda_drive_low = ack_q | ((state == S_RD) & ~tx[7]);
  assign mem_addr  = ctr;
  assign mem_wdata = sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= '1;
      sda_sy <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[SYNC-2:0], scl_in};
      sda_sy <= {sda_sy[SYNC-2:0], sda_in};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      sr <= '0;
      tx <= '1;
      ctr <= '0;
      bitcnt <= '0;
      full <= 1'b0;
      ack_q <= 1'b0;
      rw <= 1'b0;
      mack <= 1'b1;
      sel <= 1'b0;
      mem_we <= 1'b0;
      stop_pulse <= 1'b0;
    end else begin
      mem_we <= 1'b0;
      stop_pulse <= 1'b0;
      if (stop_c) begin
        state <= S_IDLE;
        ack_q <= 1'b0;
        full <= 1'b0;
        stop_pulse <= sel;
        sel <= 1'b0;
      end else if (start_c) begin
        state <= S_DEV;
        ack_q <= 1'b0;
        full <= 1'b0;
        bitcnt <= '0;
        sel <= 1'b0;
      end else begin
        case (state)
          S_DEV, S_REG, S_WR: begin
            if (scl_rise) begin
              sr <= {sr[6:0], sda_s};
              bitcnt <= bitcnt + 3'd1;
              if (bitcnt == 3'd7) full <= 1'b1;
            end else if (scl_fall && full) begin
              full <= 1'b0;
              bitcnt <= '0;
              if (state == S_DEV) begin
                if (sr[7:1] == dev_addr && !busy) begin
                  ack_q <= 1'b1;
                  rw <= sr[0];
                  sel <= 1'b1;
                  state <= S_DEV_ACK;
                end else begin
                  state <= S_IDLE;
                end
              end else if (state == S_REG) begin
                ctr <= sr;
                ack_q <= 1'b1;
                state <= S_REG_ACK;
              end else begin
                mem_we <= 1'b1;
                ack_q <= 1'b1;
                state <= S_WR_ACK;
              end
            end
          end
          S_DEV_ACK: if (scl_fall) begin
            ack_q <= 1'b0;
            if (rw) begin
              tx <= mem_rdata;
              bitcnt <= '0;
              state <= S_RD;
            end else begin
              state <= S_REG;
            end
          end
          S_REG_ACK: if (scl_fall) begin
            ack_q <= 1'b0;
            state <= S_WR;
          end
          S_WR_ACK: if (scl_fall) begin
            ack_q <= 1'b0;
            ctr <= ctr + 8'd1;
            state <= S_WR;
          end
          S_RD: if (scl_fall) begin
            if (bitcnt == 3'd7) begin
              ctr <= ctr + 8'd1;
              state <= S_RD_ACK;
            end else begin
              tx <= {tx[6:0], 1'b1};
              bitcnt <= bitcnt + 3'd1;
            end
          end
          S_RD_ACK: begin
            if (scl_rise) begin
              mack <= sda_s;
            end else if (scl_fall) begin
              if (!mack) begin
                tx <= mem_rdata;
                bitcnt <= '0;
                state <= S_RD;
              end else begin
                state <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

module i2c_mem_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_in,
  input logic       sda_drive_low,
  input logic       mem_we,
  input logic       stop_pulse,
  input logic [7:0] mem_addr
);

  assert_quiet_in_reset_R9: assert property (@(posedge clk)
    !rst_n |-> (!sda_drive_low && !mem_we && !stop_pulse && mem_addr == 8'd0));

  assert_we_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  assert_we_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !scl_in);

  assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> mem_addr == $past(mem_addr));

  assert_stop_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pulse |=> !stop_pulse);

  assert_drive_scl_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_drive_low) |-> !scl_in);

endmodule

bind i2c_mem_slave i2c_mem_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_drive_low(sda_drive_low),
  .mem_we(mem_we), .stop_pulse(stop_pulse), .mem_addr(mem_addr)
);

// File: tb/sim_i2c_mem_slave.sv
module sim_i2c_mem_slave;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr_sel = 1'b0, busy = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_drive_low, mem_we, stop_pulse;
  logic [7:0] mem_addr, mem_wdata, mem_rdata;
  logic sda_line;

  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  logic [7:0] log_addr [16];
  logic [7:0] log_data [16];
  int we_cnt = 0, stop_cnt = 0, drv_cnt = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  assign sda_line = sda_m & ~sda_drive_low;
  assign mem_rdata = mem[mem_addr];

  i2c_mem_slave u0 (
    .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .busy(busy),
    .scl_in(scl_m), .sda_in(sda_line), .sda_drive_low(sda_drive_low),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_rdata(mem_rdata), .stop_pulse(stop_pulse)
  );

  always @(negedge clk) begin
    if (mem_we) begin
      mem[mem_addr] = mem_wdata;
      if (we_cnt < 16) begin
        log_addr[we_cnt] = mem_addr;
        log_data[we_cnt] = mem_wdata;
      end
      we_cnt++;
    end
    if (stop_pulse) stop_cnt++;
    if (sda_drive_low) drv_cnt++;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hp();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1; scl_m = 1; hp(); sda_m = 0; hp(); scl_m = 0; hp();
  endtask

  task automatic bus_rstart();
    sda_m = 1; hp(); scl_m = 1; hp(); sda_m = 0; hp(); scl_m = 0; hp();
  endtask

  task automatic bus_stop();
    sda_m = 0; hp(); scl_m = 1; hp(); sda_m = 1; hp();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hp(); scl_m = 1; hp(); hp(); scl_m = 0; hp();
    end
    sda_m = 1; hp(); scl_m = 1; hp(); ack = ~sda_line; hp(); scl_m = 0; hp();
  endtask

  task automatic recv_byte(input logic master_ack, output logic [7:0] b);
    b = 8'h00;
    sda_m = 1;
    for (int i = 0; i < 8; i++) begin
      hp(); scl_m = 1; hp(); b = {b[6:0], sda_line}; hp(); scl_m = 0; hp();
    end
    sda_m = ~master_ack; hp(); scl_m = 1; hp(); hp(); scl_m = 0; hp();
    sda_m = 1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] rb;
    int s0, w0, d0;
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i) ^ 8'h5A;
      exp_mem[i] = 8'(i) ^ 8'h5A;
    end
    repeat (3) @(negedge clk);
    check("R9 drive in reset", sda_drive_low, 0);
    check("R9 we in reset", mem_we, 0);
    check("R9 stop in reset", stop_pulse, 0);
    check("R9 counter in reset", mem_addr, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 / R8: sweep every 7-bit address for both select values
    for (int s = 0; s < 2; s++) begin
      addr_sel = s[0];
      s0 = stop_cnt;
      for (int a = 0; a < 128; a++) begin
        bus_start();
        send_byte({a[6:0], 1'b0}, ack);
        bus_stop();
        check($sformatf("R1 ack sel=%0d addr=%0h", s, a), ack, (a == (8'h50 | s)) ? 1 : 0);
      end
      check("R8 one pulse per sweep", stop_cnt - s0, 1);
    end
    check("R1 no writes from address-only", we_cnt, 0);

    // R3 / R4: write burst from FCh across the top
    addr_sel = 1;
    s0 = stop_cnt;
    bus_start();
    send_byte(8'hA2, ack); check("R1 write address ack", ack, 1);
    send_byte(8'hFC, ack); check("R3 memory address ack", ack, 1);
    for (int k = 0; k < 6; k++) begin
      send_byte(8'h30 + 8'(k), ack);
      check("R3 data ack", ack, 1);
      exp_mem[8'(8'hFC + k)] = 8'h30 + 8'(k);
    end
    bus_stop();
    check("R3 strobe count", we_cnt, 6);
    for (int k = 0; k < 6; k++) begin
      check("R4 write address", log_addr[k], 8'(8'hFC + k));
      check("R3 write data", log_data[k], 8'h30 + 8'(k));
    end
    check("R8 pulse after write", stop_cnt - s0, 1);

    // R5: bare reads continue from the counter
    bus_start();
    send_byte(8'hA3, ack); check("R5 read address ack", ack, 1);
    recv_byte(1, rb); check("R5 read 02", rb, exp_mem[8'h02]);
    recv_byte(1, rb); check("R7 read 03", rb, exp_mem[8'h03]);
    recv_byte(0, rb); check("R7 read 04", rb, exp_mem[8'h04]);
    bus_stop();
    bus_start();
    send_byte(8'hA3, ack);
    recv_byte(0, rb); check("R5 persistent counter 05", rb, exp_mem[8'h05]);
    bus_stop();

    // R6 / R4: dummy write then read across FFh
    w0 = we_cnt;
    bus_start();
    send_byte(8'hA2, ack);
    send_byte(8'hFE, ack);
    bus_rstart();
    send_byte(8'hA3, ack); check("R6 restart address ack", ack, 1);
    recv_byte(1, rb); check("R6 read FE", rb, exp_mem[8'hFE]);
    recv_byte(1, rb); check("R4 read FF", rb, exp_mem[8'hFF]);
    recv_byte(1, rb); check("R4 roll to 00", rb, exp_mem[8'h00]);
    recv_byte(0, rb); check("R4 read 01", rb, exp_mem[8'h01]);
    bus_stop();
    check("R6 dummy write no strobe", we_cnt - w0, 0);

    // R7: after NACK the slave stays off the line
    bus_start();
    send_byte(8'hA3, ack);
    recv_byte(0, rb); check("R7 read 02", rb, exp_mem[8'h02]);
    d0 = drv_cnt;
    for (int i = 0; i < 9; i++) begin
      hp(); scl_m = 1; hp(); hp(); scl_m = 0; hp();
    end
    check("R7 released after NACK", drv_cnt - d0, 0);
    bus_stop();

    // R2: busy suppresses the address acknowledge
    busy = 1;
    s0 = stop_cnt; w0 = we_cnt;
    bus_start();
    send_byte(8'hA2, ack); check("R2 busy address nack", ack, 0);
    send_byte(8'h40, ack); check("R2 busy byte nack", ack, 0);
    send_byte(8'h41, ack); check("R2 busy data nack", ack, 0);
    bus_stop();
    check("R2 busy no strobe", we_cnt - w0, 0);
    check("R2 busy no pulse", stop_cnt - s0, 0);
    busy = 0;
    bus_start();
    send_byte(8'hA2, ack); check("R2 ack after busy drops", ack, 1);
    bus_stop();

    // R10: stop in the middle of a data byte
    w0 = we_cnt;
    bus_start();
    send_byte(8'hA2, ack);
    send_byte(8'h10, ack);
    for (int i = 0; i < 3; i++) begin
      sda_m = 1; hp(); scl_m = 1; hp(); hp(); scl_m = 0; hp();
    end
    bus_stop();
    check("R10 aborted byte no strobe", we_cnt - w0, 0);
    bus_start();
    send_byte(8'hA3, ack);
    recv_byte(0, rb); check("R10 counter kept at 10", rb, exp_mem[8'h10]);
    bus_stop();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule